// File: doc/BRIEF.md
# Accumulator ALU with BCD adjust

This block is the 8-bit arithmetic and logic unit of an accumulator-based microcontroller core. Each operation takes the accumulator value, a second operand byte (the B register for multiply and divide, any byte otherwise), the carry flag and the auxiliary-carry flag. It returns a new accumulator value and a new second-operand value, plus new carry, auxiliary-carry and overflow flags. Each result comes with its own write enable, so the surrounding core writes back only what the operation changes. The register file and the status word storage belong to the core.

An operation is issued by raising `start` for one cycle with the operation code on `op`. Every operation except divide is computed combinationally and registered, so its result shows up with `done` in the following cycle. Divide runs a restoring shift-subtract loop, one quotient bit per cycle, and holds `busy` high until it finishes. The flag rules are irregular by design. Subtract always takes the borrow in. Increment and decrement touch no flag. Bitwise, clear, swap and plain rotates also touch no flag. Multiply and divide always clear carry. A decimal-adjust step fixes up the accumulator after a packed-BCD addition.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) gives A = acc + operand and code 1 (add with carry) gives A = acc + operand + C. For both, C is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the signed 8-bit result overflows. A, C, AC and OV are all written.
- R2: Code 2 (subtract with borrow) gives A = acc − operand − C, with C as the borrow out of bit 7, AC as the borrow out of bit 3 and OV as signed overflow. A, C, AC and OV are all written.
- R3: Code 3 (increment) and code 4 (decrement) give acc ± 1 modulo 256. They write A only and raise no flag enable.
- R4: Code 5 (multiply) forms the 16-bit product of acc and operand. The low byte goes to A and the high byte to B (FFh × FFh gives A = 01h, B = FEh). C is written 0, and OV is written 1 exactly when the product exceeds FFh.
- R5: Code 6 (divide) writes the quotient acc/operand to A, the remainder to B, and writes C = 0 and OV = 0. With a zero divisor it writes OV = 1 and C = 0 and leaves A and B unwritten.
- R6: Code 7 (decimal adjust) adds 06h when the low nibble is above 9 or AC is 1. It then adds 60h when the high nibble of that sum is above 9, C is 1, or the first addition carried. It writes A and C, where C becomes 1 on any carry out of bit 7 and otherwise keeps its input value (4Ch with flags clear gives 52h).
- R7: Codes 8 AND, 9 OR, 10 XOR (each with the operand), 11 complement, 12 clear, 13 rotate left, 15 rotate right and 17 nibble swap write A only and raise no flag enable (F0h rotated right gives 78h).
- R8: Code 14 rotates A left through C and code 16 rotates A right through C, treating C as a ninth bit. Each writes A and C and no other flag.
- R9: Code 18 (low-nibble exchange) swaps bits 3..0 of acc with bits 3..0 of the operand, keeps both high nibbles, writes A and B and raises no flag enable.
- R10: `start` is accepted when `busy` is low. An accepted operation other than divide raises `done` for exactly one cycle, in the next cycle. An accepted divide holds `busy` high for the following 7 cycles and raises `done` 8 cycles after the start cycle. Write enables are high only together with `done`.
- R11: A `start` raised while `busy` is high is ignored and produces no `done`.
- R12: Codes 19 to 31 are unused. An accepted unused code raises `done` in the next cycle with all five write enables low.
- R13: While `rst_n` is low at a clock edge, `done`, `busy` and all write enables are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue the operation on `op` this cycle |
| op | input | 5 | Operation code (see R1–R12 for values) |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte (B for multiply/divide) |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Result valid this cycle |
| acc_o | output | 8 | New accumulator value |
| b_o | output | 8 | New second-operand value |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary-carry flag |
| ov_o | output | 1 | New overflow flag |
| acc_we | output | 1 | Write accumulator |
| b_we | output | 1 | Write second operand |
| cy_we | output | 1 | Write carry |
| ac_we | output | 1 | Write auxiliary carry |
| ov_we | output | 1 | Write overflow |

## Verification
Every single-cycle operation and every unused code is due in the cycle right after its start cycle. A divide is due exactly eight cycles after its start cycle, whatever the divisor. When the driver issues an operation it records the due cycle next to the expected values. The monitor samples on the falling clock edge, and each time `done` is high it compares the current cycle number with that recorded due cycle. A `done` that arrives with nothing pending, including one that would follow a start ignored during a divide, is reported as a failure.

// File: rtl/alu8_pkg.sv
// Package: shared widths, operation codes and the result record of the ALU.
// Assumes an 8-bit datapath split into two nibbles for the BCD rules.
package alu8_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
        OP_DEC  = 5'd4,  OP_MUL  = 5'd5,  OP_DIV  = 5'd6,  OP_DA   = 5'd7,
        OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CPL  = 5'd11,
        OP_CLR  = 5'd12, OP_RL   = 5'd13, OP_RLC  = 5'd14, OP_RR   = 5'd15,
        OP_RRC  = 5'd16, OP_SWAP = 5'd17, OP_XCHD = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          cy;
        logic          ac;
        logic          ov;
        logic          a_we;
        logic          b_we;
        logic          cy_we;
        logic          ac_we;
        logic          ov_we;
    } alu_res_t;
endpackage

// File: rtl/alu8_arith.sv
// Module: combinational add, add-with-carry, subtract-with-borrow,
// increment, decrement and decimal adjust. Raises hit for its own codes.
// Assumes op is stable for the cycle; all outputs are combinational.
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cy,
    input  logic          ac,
    output alu_res_t      res,
    output logic          hit
);
    localparam logic [DW:0]   LO_FIX = (DW+1)'(6);
    localparam logic [DW:0]   HI_FIX = LO_FIX << NW;
    localparam logic [NW-1:0] NIB_MAX = NW'(9);

    logic          cin;
    logic [DW:0]   sum;
    logic [DW:0]   dif;
    logic          lo_fix;
    logic          hi_fix;
    logic [DW:0]   da_t1;
    logic [DW:0]   da_t2;

    // Adder, subtractor and the two decimal-adjust stages.
    always_comb begin
        cin    = (op == OP_ADDC) ? cy : 1'b0;
        sum    = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        dif    = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cy};
        lo_fix = ac || (a[NW-1:0] > NIB_MAX);
        da_t1  = {1'b0, a} + (lo_fix ? LO_FIX : '0);
        hi_fix = cy || da_t1[DW] || (da_t1[DW-1:NW] > NIB_MAX);
        da_t2  = da_t1 + (hi_fix ? HI_FIX : '0);
    end

    // Pick the result and write enables for the selected operation.
    always_comb begin
        res = '0;
        res.b = b;
        hit = 1'b1;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res.a  = sum[DW-1:0];
                res.cy = sum[DW];
                res.ac = a[NW] ^ b[NW] ^ sum[NW];
                res.ov = a[DW-1] ^ b[DW-1] ^ sum[DW-1] ^ sum[DW];
                res.a_we = 1'b1; res.cy_we = 1'b1; res.ac_we = 1'b1; res.ov_we = 1'b1;
            end
            OP_SUBB: begin
                res.a  = dif[DW-1:0];
                res.cy = dif[DW];
                res.ac = a[NW] ^ b[NW] ^ dif[NW];
                res.ov = a[DW-1] ^ b[DW-1] ^ dif[DW-1] ^ dif[DW];
                res.a_we = 1'b1; res.cy_we = 1'b1; res.ac_we = 1'b1; res.ov_we = 1'b1;
            end
            OP_INC: begin
                res.a = a + DW'(1);
                res.a_we = 1'b1;
            end
            OP_DEC: begin
                res.a = a - DW'(1);
                res.a_we = 1'b1;
            end
            OP_DA: begin
                res.a  = da_t2[DW-1:0];
                res.cy = cy | da_t1[DW] | da_t2[DW];
                res.a_we = 1'b1; res.cy_we = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: combinational bitwise, clear, rotate, swap and low-nibble
// exchange. Only the through-carry rotates produce a flag.
// Assumes op is stable for the cycle; all outputs are combinational.
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cy,
    output alu_res_t      res,
    output logic          hit
);
    // Select the logic result and the registers it writes.
    always_comb begin
        res = '0;
        res.b = b;
        res.a_we = 1'b1;
        hit = 1'b1;
        unique case (op)
            OP_AND:  res.a = a & b;
            OP_OR:   res.a = a | b;
            OP_XOR:  res.a = a ^ b;
            OP_CPL:  res.a = ~a;
            OP_CLR:  res.a = '0;
            OP_RL:   res.a = {a[DW-2:0], a[DW-1]};
            OP_RR:   res.a = {a[0], a[DW-1:1]};
            OP_RLC: begin
                res.a = {a[DW-2:0], cy};
                res.cy = a[DW-1];
                res.cy_we = 1'b1;
            end
            OP_RRC: begin
                res.a = {cy, a[DW-1:1]};
                res.cy = a[0];
                res.cy_we = 1'b1;
            end
            OP_SWAP: res.a = {a[NW-1:0], a[DW-1:NW]};
            OP_XCHD: begin
                res.a = {a[DW-1:NW], b[NW-1:0]};
                res.b = {b[DW-1:NW], a[NW-1:0]};
                res.b_we = 1'b1;
            end
            default: begin
                res.a_we = 1'b0;
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_muldiv.sv
// Module: combinational multiply and an iterative restoring divider that
// retires one quotient bit per cycle. The first bit is formed in the start
// cycle, so the divide takes DW cycles in total.
// Assumes start_div is only raised while busy is low.
module alu8_muldiv
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_div,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output alu_res_t      mul_res,
    output logic          busy,
    output logic          fin,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem,
    output logic          dz
);
    localparam int CW = $clog2(DW + 1);

    logic [2*DW-1:0] prod;
    logic [DW-1:0]   rem_q;
    logic [DW-1:0]   quo_q;
    logic [DW-1:0]   dvs_q;
    logic [CW-1:0]   cnt_q;
    logic [DW-1:0]   src_rem;
    logic [DW-1:0]   src_quo;
    logic [DW-1:0]   dvs;
    logic [DW:0]     trial;
    logic [DW:0]     diff;

    // Multiply result: low byte to A, high byte to B, C cleared.
    always_comb begin
        prod = a * b;
        mul_res = '0;
        mul_res.a  = prod[DW-1:0];
        mul_res.b  = prod[2*DW-1:DW];
        mul_res.ov = |prod[2*DW-1:DW];
        mul_res.a_we = 1'b1; mul_res.b_we = 1'b1;
        mul_res.cy_we = 1'b1; mul_res.ov_we = 1'b1;
    end

    // One restoring step, seeded from the inputs in the start cycle.
    always_comb begin
        src_rem = busy ? rem_q : '0;
        src_quo = busy ? quo_q : a;
        dvs     = busy ? dvs_q : b;
        trial   = {src_rem, src_quo[DW-1]};
        diff    = trial - {1'b0, dvs};
        rem     = diff[DW] ? trial[DW-1:0] : diff[DW-1:0];
        quo     = {src_quo[DW-2:0], ~diff[DW]};
    end

    // Iteration state: partial remainder, quotient, divisor, step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (start_div) begin
            rem_q <= rem;
            quo_q <= quo;
            dvs_q <= b;
            cnt_q <= CW'(DW - 1);
            busy  <= 1'b1;
        end else if (busy) begin
            rem_q <= rem;
            quo_q <= quo;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) busy <= 1'b0;
        end
    end

    assign fin = busy && (cnt_q == CW'(1));
    assign dz  = (dvs_q == '0);
endmodule

// File: rtl/alu8_core.sv
// Module: ALU top. Accepts an operation when idle, registers single-cycle
// results for one cycle of done, and hands divide to the iterative engine.
// Assumes the core holds acc_i/opnd_i only in the start cycle.
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [4:0]    op,
    input  logic [7:0]    acc_i,
    input  logic [7:0]    opnd_i,
    input  logic          cy_i,
    input  logic          ac_i,
    output logic          busy,
    output logic          done,
    output logic [7:0]    acc_o,
    output logic [7:0]    b_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o,
    output logic          acc_we,
    output logic          b_we,
    output logic          cy_we,
    output logic          ac_we,
    output logic          ov_we
);
    alu_op_e       op_e;
    logic          accept;
    alu_res_t      ar_res, lg_res, mul_res, nxt, div_res, res_q;
    logic          ar_hit, lg_hit;
    logic          div_fin, div_dz;
    logic [DW-1:0] div_quo, div_rem;
    logic          done_q;

    assign op_e   = alu_op_e'(op);
    assign accept = start && !busy;

    alu8_arith u_arith (
        .op(op_e), .a(acc_i), .b(opnd_i), .cy(cy_i), .ac(ac_i),
        .res(ar_res), .hit(ar_hit)
    );

    alu8_logic u_logic (
        .op(op_e), .a(acc_i), .b(opnd_i), .cy(cy_i),
        .res(lg_res), .hit(lg_hit)
    );

    alu8_muldiv u_muldiv (
        .clk(clk), .rst_n(rst_n), .start_div(accept && (op_e == OP_DIV)),
        .a(acc_i), .b(opnd_i), .mul_res(mul_res), .busy(busy),
        .fin(div_fin), .quo(div_quo), .rem(div_rem), .dz(div_dz)
    );

    // Merge the single-cycle units; unused codes leave every enable low.
    always_comb begin
        nxt = '0;
        if (ar_hit)               nxt = ar_res;
        else if (lg_hit)          nxt = lg_res;
        else if (op_e == OP_MUL)  nxt = mul_res;
    end

    // Divide write-back: zero divisor flags OV and skips A and B.
    always_comb begin
        div_res = '0;
        div_res.a  = div_quo;
        div_res.b  = div_rem;
        div_res.ov = div_dz;
        div_res.a_we = !div_dz; div_res.b_we = !div_dz;
        div_res.cy_we = 1'b1; div_res.ov_we = 1'b1;
    end

    // Result register and one-cycle done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else if (div_fin) begin
            res_q  <= div_res;
            done_q <= 1'b1;
        end else if (accept && (op_e != OP_DIV)) begin
            res_q  <= nxt;
            done_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done   = done_q;
    assign acc_o  = res_q.a;
    assign b_o    = res_q.b;
    assign cy_o   = res_q.cy;
    assign ac_o   = res_q.ac;
    assign ov_o   = res_q.ov;
    assign acc_we = done_q & res_q.a_we;
    assign b_we   = done_q & res_q.b_we;
    assign cy_we  = done_q & res_q.cy_we;
    assign ac_we  = done_q & res_q.ac_we;
    assign ov_we  = done_q & res_q.ov_we;
endmodule

// File: rtl/alu8_core_chk.sv
// Checker: timing and flag-enable properties of alu8_core, seen at its ports.
// Assumes it is bound to every alu8_core instance.
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [4:0] op,
    input logic [7:0] acc_i,
    input logic [7:0] opnd_i,
    input logic       cy_i,
    input logic       busy,
    input logic       done,
    input logic [7:0] acc_o,
    input logic [7:0] b_o,
    input logic       cy_o,
    input logic       ov_o,
    input logic       acc_we,
    input logic       b_we,
    input logic       cy_we,
    input logic       ac_we,
    input logic       ov_we
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] DWC = CW'(DW);

    logic          acc_ok;
    logic [CW-1:0] dcnt;

    assign acc_ok = start && !busy;

    // Cycle count since an accepted divide; reaches DW in its done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                           dcnt <= '0;
        else if (acc_ok && op == 5'(OP_DIV))  dcnt <= CW'(1);
        else if (dcnt != '0 && dcnt < DWC)    dcnt <= dcnt + CW'(1);
        else                                  dcnt <= '0;
    end

    // R1
    add_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && (op == 5'(OP_ADD) || op == 5'(OP_ADDC))
        |=> done && acc_we && cy_we && ac_we && ov_we && !b_we);

    // R3
    incdec_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && (op == 5'(OP_INC) || op == 5'(OP_DEC))
        |=> done && acc_we && !cy_we && !ac_we && !ov_we && !b_we);

    // R4
    mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 5'(OP_MUL)
        |=> done && cy_we && !cy_o && ov_we && (ov_o == (b_o != 8'h00)));

    // R7
    logic_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op >= 5'(OP_AND) && op <= 5'(OP_SWAP)
        && op != 5'(OP_RLC) && op != 5'(OP_RRC)
        |=> done && acc_we && !cy_we && !ac_we && !ov_we);

    // R8
    rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 5'(OP_RLC)
        |=> cy_we && !ac_we && (cy_o == $past(acc_i[7])) && (acc_o[0] == $past(cy_i)));

    // R9
    xchd_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op == 5'(OP_XCHD)
        |=> acc_we && b_we && !cy_we && (acc_o[3:0] == $past(opnd_i[3:0]))
            && (b_o[3:0] == $past(acc_i[3:0])));

    // R10
    div_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt != '0 && dcnt < DWC) |-> busy && !done);

    // R10
    div_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcnt == DWC) |-> done && cy_we && ov_we);

    // R12
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok && op > 5'(OP_XCHD)
        |=> done && !acc_we && !b_we && !cy_we && !ac_we && !ov_we);

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !done && !busy && !acc_we && !cy_we);
endmodule

bind alu8_core alu8_core_chk chk_i (.*);

// File: tb/alu8_core_tb_top.sv
// Bench: scoreboard. The driver task computes expected results from the
// requirements and queues them with a due cycle; the monitor compares.
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic       cy_i = 1'b0, ac_i = 1'b0;
    logic       busy, done, cy_o, ac_o, ov_o;
    logic [7:0] acc_o, b_o;
    logic       acc_we, b_we, cy_we, ac_we, ov_we;

    alu8_core dut_i (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int due; string tag;
        int a, b; bit cy, ac, ov;
        bit aw, bw, cw, acw, ow;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int n_chk = 0, n_fail = 0;

    task automatic check(bit ok, string tag, string what, int act, int ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, ex);
        end
    endtask

    function automatic int sx(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // Expected result straight from the requirement text.
    function automatic exp_t model(int o, int a, int b, bit c, bit h);
        exp_t r;
        int t, s;
        r = '{due: 0, tag: "R12", a: a, b: b, cy: 0, ac: 0, ov: 0,
              aw: 0, bw: 0, cw: 0, acw: 0, ow: 0};
        case (o)
            0, 1: begin
                t = (o == 1) ? int'(c) : 0;
                r.tag = "R1"; r.a = (a + b + t) & 255; r.cy = (a + b + t) > 255;
                r.ac = ((a & 15) + (b & 15) + t) > 15;
                s = sx(a) + sx(b) + t; r.ov = (s > 127) || (s < -128);
                r.aw = 1; r.cw = 1; r.acw = 1; r.ow = 1;
            end
            2: begin
                r.tag = "R2"; r.a = (a - b - int'(c)) & 255; r.cy = (a - b - int'(c)) < 0;
                r.ac = ((a & 15) - (b & 15) - int'(c)) < 0;
                s = sx(a) - sx(b) - int'(c); r.ov = (s > 127) || (s < -128);
                r.aw = 1; r.cw = 1; r.acw = 1; r.ow = 1;
            end
            3: begin r.tag = "R3"; r.a = (a + 1) & 255; r.aw = 1; end
            4: begin r.tag = "R3"; r.a = (a + 255) & 255; r.aw = 1; end
            5: begin
                r.tag = "R4"; r.a = (a * b) & 255; r.b = (a * b) >> 8;
                r.ov = (a * b) > 255; r.aw = 1; r.bw = 1; r.cw = 1; r.ow = 1;
            end
            6: begin
                r.tag = "R5"; r.cw = 1; r.ow = 1;
                if (b == 0) r.ov = 1;
                else begin r.a = a / b; r.b = a % b; r.aw = 1; r.bw = 1; end
            end
            7: begin
                r.tag = "R6"; t = a;
                if ((t & 15) > 9 || h) t = t + 6;
                if (((t >> 4) & 15) > 9 || c || t > 255) t = t + 96;
                r.a = t & 255; r.cy = c || (t > 255); r.aw = 1; r.cw = 1;
            end
            8:  begin r.tag = "R7"; r.a = a & b; r.aw = 1; end
            9:  begin r.tag = "R7"; r.a = a | b; r.aw = 1; end
            10: begin r.tag = "R7"; r.a = a ^ b; r.aw = 1; end
            11: begin r.tag = "R7"; r.a = 255 - a; r.aw = 1; end
            12: begin r.tag = "R7"; r.a = 0; r.aw = 1; end
            13: begin r.tag = "R7"; r.a = ((a << 1) | (a >> 7)) & 255; r.aw = 1; end
            15: begin r.tag = "R7"; r.a = ((a >> 1) | (a << 7)) & 255; r.aw = 1; end
            17: begin r.tag = "R7"; r.a = ((a << 4) | (a >> 4)) & 255; r.aw = 1; end
            14: begin r.tag = "R8"; r.a = ((a << 1) | int'(c)) & 255; r.cy = a[7]; r.aw = 1; r.cw = 1; end
            16: begin r.tag = "R8"; r.a = (a >> 1) | (int'(c) << 7); r.cy = a[0]; r.aw = 1; r.cw = 1; end
            18: begin
                r.tag = "R9"; r.a = (a & 240) | (b & 15); r.b = (b & 240) | (a & 15);
                r.aw = 1; r.bw = 1;
            end
            default: ;
        endcase
        return r;
    endfunction

    // Queue the expectation and pulse start; return once the result is out.
    task automatic issue(int o, int a, int b, bit c, bit h);
        exp_t x;
        x = model(o, a, b, c, h);
        x.due = cyc + ((o == 6) ? 8 : 1);
        q.push_back(x);
        op = 5'(o); acc_i = 8'(a); opnd_i = 8'(b); cy_i = c; ac_i = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare on every done, at the falling edge.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R11", "done with nothing pending", 1, 0);
            end else begin
                e = q.pop_front();
                check(cyc == e.due, "R10", "done cycle", cyc, e.due);
                check({acc_we, b_we, cy_we, ac_we, ov_we} == {e.aw, e.bw, e.cw, e.acw, e.ow},
                      e.tag, "write enables", int'({acc_we, b_we, cy_we, ac_we, ov_we}),
                      int'({e.aw, e.bw, e.cw, e.acw, e.ow}));
                if (e.aw)  check(int'(acc_o) == e.a, e.tag, "A", int'(acc_o), e.a);
                if (e.bw)  check(int'(b_o) == e.b, e.tag, "B", int'(b_o), e.b);
                if (e.cw)  check(cy_o == e.cy, e.tag, "C", int'(cy_o), int'(e.cy));
                if (e.acw) check(ac_o == e.ac, e.tag, "AC", int'(ac_o), int'(e.ac));
                if (e.ow)  check(ov_o == e.ov, e.tag, "OV", int'(ov_o), int'(e.ov));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: quiet outputs after reset edges
        check(!done && !busy && {acc_we, b_we, cy_we, ac_we, ov_we} == 5'b0, "R13",
              "reset state", int'({done, busy, acc_we, cy_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(0, 8'h23, 8'h29, 1'b1, 1'b0);   // R1 plain add ignores C
        issue(7, 8'h4C, 8'h00, 1'b0, 1'b0);   // R6 4Ch -> 52h
        issue(1, 8'h7F, 8'h00, 1'b1, 1'b0);   // R1 signed overflow via carry in
        issue(1, 8'hF8, 8'h0C, 1'b0, 1'b0);   // R1 carry out of bit 7
        issue(2, 8'h40, 8'h4F, 1'b1, 1'b0);   // R2 borrow and AC
        issue(2, 8'h80, 8'h01, 1'b0, 1'b0);   // R2 signed overflow
        issue(3, 8'hFF, 8'h00, 1'b1, 1'b1);   // R3 wrap up
        issue(4, 8'h00, 8'h00, 1'b0, 1'b0);   // R3 wrap down
        issue(5, 8'hFF, 8'hFF, 1'b1, 1'b0);   // R4 FE01h
        issue(5, 8'h0F, 8'h11, 1'b1, 1'b0);   // R4 product fits in a byte
        issue(6, 8'd200, 8'd7, 1'b1, 1'b0);   // R5 quotient and remainder
        issue(6, 8'h55, 8'h00, 1'b1, 1'b0);   // R5 zero divisor
        issue(6, 8'h03, 8'hFF, 1'b0, 1'b0);   // R5 divisor larger than dividend
        issue(7, 8'h9A, 8'h00, 1'b0, 1'b0);   // R6 both nibbles adjust, carry out
        issue(7, 8'h12, 8'h00, 1'b1, 1'b1);   // R6 adjust forced by AC and C
        issue(8, 8'hAC, 8'h0F, 1'b1, 1'b1);   // R7 AND
        issue(9, 8'hAC, 8'h0F, 1'b0, 1'b0);   // R7 OR
        issue(10, 8'hAC, 8'h0F, 1'b0, 1'b0);  // R7 XOR
        issue(11, 8'hAC, 8'h00, 1'b1, 1'b0);  // R7 complement
        issue(12, 8'hAC, 8'h00, 1'b0, 1'b0);  // R7 clear
        issue(13, 8'h81, 8'h00, 1'b0, 1'b0);  // R7 rotate left
        issue(15, 8'hF0, 8'h00, 1'b1, 1'b0);  // R7 F0h -> 78h
        issue(17, 8'h5A, 8'h00, 1'b0, 1'b0);  // R7 swap
        issue(14, 8'h80, 8'h00, 1'b0, 1'b0);  // R8 rotate left through C
        issue(16, 8'h01, 8'h00, 1'b1, 1'b0);  // R8 rotate right through C
        issue(18, 8'h3C, 8'hA5, 1'b0, 1'b0);  // R9 low-nibble exchange
        issue(25, 8'h11, 8'h22, 1'b1, 1'b1);  // R12 unused code
        issue(31, 8'h11, 8'h22, 1'b0, 1'b0);  // R12 unused code
        // R11: start raised mid-divide must be ignored
        e = model(6, 8'd250, 8'd16, 1'b0, 1'b0);
        e.due = cyc + 8;
        q.push_back(e);
        op = 5'd6; acc_i = 8'd250; opnd_i = 8'd16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 5'd0; acc_i = 8'h01; opnd_i = 8'h01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R10", "results still pending", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule